// File: doc/BRIEF.md
# Octave Clock Divider with Complementary Outputs

This block derives a square-wave clock from a fast reference clock. It divides by one of sixteen powers of two, chosen by a 4-bit octave code. Each step up in the code doubles the output frequency. The reference input runs at twice the nominal master rate, so every output half-period is a whole number of reference cycles. Octave 15 gives a half-period of one reference cycle, which is a divide ratio of 1 against the master rate. Octave 0 gives a half-period of 32768 reference cycles.

A serial front end delivers a 16-bit settings word with a one-cycle strobe. The word carries the octave code, a 10-bit frequency-trim field and a 2-bit output configuration. The trim field only passes through to the analog master oscillator. The configuration selects which of the two outputs toggles: the main output, the auxiliary output (the complement of the main output), both, or neither (sleep). A new octave waits for the running half-period to end, so no runt pulse appears. An output-enable input forces both outputs low at once, without waiting for a clock edge.

Top module: `octave_clock_divider`

## Requirements
- R1: After reset the octave is 0 and the configuration is both-outputs. The main output is low, the auxiliary output is high and the trim output is 0. The main output first rises 32768 reference cycles after reset is released.
- R2: With octave code N, each output half-period lasts exactly 2^(15-N) reference cycles.
- R3: Configuration 2'b00 runs both outputs. While enabled, the auxiliary output is always the inverse of the main output.
- R4: Configuration 2'b01 holds the auxiliary output low while the main output keeps toggling.
- R5: Configuration 2'b10 holds the main output low while the auxiliary output keeps toggling.
- R6: Configuration 2'b11 (sleep) holds both outputs low and keeps the divider counter and phase cleared.
- R7: On leaving sleep, the divider restarts from zero with the main output low. The main output first rises one full half-period of the current octave after the update edge.
- R8: While output-enable is low, both outputs are low in the same time step, with no clock edge needed.
- R9: A new octave code takes effect only at the end of the running half-period. An update that arrives on the very cycle that ends a half-period is applied at that boundary.
- R10: The settings word holds the octave in bits 15:12, the trim in bits 11:2 and the configuration in bits 1:0. The trim output and the configuration take their new values on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the master rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| upd_valid_i | input | 1 | One-cycle strobe for a new settings word |
| upd_word_i | input | 16 | Settings word: octave, trim, configuration |
| oe_i | input | 1 | Output enable; low forces both outputs low asynchronously |
| clk_main_o | output | 1 | Main divided clock |
| clk_aux_o | output | 1 | Auxiliary clock, inverse of main |
| dac_code_o | output | 10 | Registered trim field for the master oscillator |

## Verification
Two events can fall in the same cycle: an octave update strobe, and the terminal count that ends a half-period. The bench provokes this by timing the strobe against a restart whose edge is known. In one case the strobe lands exactly on the boundary edge; in the other it lands one cycle after a boundary. The bench judges the two cases by the length of the half-period that follows. An update on the boundary must give the new length at once. An update one cycle late must leave the old length in force until the next boundary. The bench also drops output-enable between clock edges and checks that the outputs fall in that same time step.

// File: rtl/octdiv_pkg.sv
package octdiv_pkg;

   // Output configuration code carried in the low two bits of the settings word.
   typedef enum logic [1:0] {
      CFG_BOTH      = 2'b00,
      CFG_MAIN_ONLY = 2'b01,
      CFG_AUX_ONLY  = 2'b10,
      CFG_SLEEP     = 2'b11
   } out_cfg_e;

   localparam int unsigned CFG_W = 2;

   function automatic logic main_enabled(input out_cfg_e c);
      return (c == CFG_BOTH) || (c == CFG_MAIN_ONLY);
   endfunction

   function automatic logic aux_enabled(input out_cfg_e c);
      return (c == CFG_BOTH) || (c == CFG_AUX_ONLY);
   endfunction

endpackage

// File: rtl/octdiv_regs.sv
module octdiv_regs
   import octdiv_pkg::*;
#(
   parameter int unsigned OCT_W = 4,
   parameter int unsigned DAC_W = 10,
   localparam int unsigned WORD_W = OCT_W + DAC_W + CFG_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               upd_valid_i,
   input  logic [WORD_W-1:0]  upd_word_i,
   output logic [OCT_W-1:0]   oct_nxt_o,
   output out_cfg_e           cfg_o,
   output logic [DAC_W-1:0]   dac_o
);

   if (DAC_W < 1) begin : g_bad_dac
      $error("octdiv_regs: DAC_W must be at least 1");
   end

   logic [OCT_W-1:0] oct_field;
   logic [DAC_W-1:0] dac_field;
   logic [CFG_W-1:0] cfg_field;
   logic [OCT_W-1:0] oct_pend_q;

   // Field split: octave on top, trim in the middle, configuration at the bottom.
   assign oct_field = upd_word_i[WORD_W-1 -: OCT_W];
   assign dac_field = upd_word_i[CFG_W +: DAC_W];
   assign cfg_field = upd_word_i[CFG_W-1:0];

   // Pending octave, with bypass so a strobe on a boundary cycle is seen there.
   assign oct_nxt_o = upd_valid_i ? oct_field : oct_pend_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         oct_pend_q <= '0;
         cfg_o      <= CFG_BOTH;
         dac_o      <= '0;
      end else if (upd_valid_i) begin
         oct_pend_q <= oct_field;
         cfg_o      <= out_cfg_e'(cfg_field);
         dac_o      <= dac_field;
      end
   end

   // R10: trim output only moves on a strobed edge
   a_r10_dac_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dac_o) |-> $past(upd_valid_i));

endmodule

// File: rtl/octdiv_counter.sv
module octdiv_counter #(
   parameter int unsigned OCT_W = 4,
   localparam int unsigned NUM_OCT = 1 << OCT_W,
   localparam int unsigned CNT_W = NUM_OCT - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sleep_i,
   input  logic [OCT_W-1:0] oct_nxt_i,
   output logic             phase_o
);

   if (OCT_W < 1 || OCT_W > 5) begin : g_bad_oct
      $error("octdiv_counter: OCT_W must lie in 1..5");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   logic [CNT_W-1:0]   cnt_q;
   logic [OCT_W-1:0]   act_q;
   logic               phase_q;
   logic [NUM_OCT-1:0] hit;
   logic               term;

   // Per-octave terminal detect: half-period of 2^B cycles ends when the low B bits are all ones.
   for (genvar o = 0; o < NUM_OCT; o++) begin : g_term
      localparam int unsigned B = NUM_OCT - 1 - o;
      if (B == 0) begin : g_unit
         assign hit[o] = 1'b1;
      end else begin : g_span
         assign hit[o] = &cnt_q[B-1:0];
      end
   end

   assign term = hit[act_q];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         act_q   <= '0;
      end else if (sleep_i) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
         act_q   <= oct_nxt_i;
      end else if (term) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
         act_q   <= oct_nxt_i;
      end else begin
         cnt_q   <= cnt_q + CNT_ONE;
      end
   end

   assign phase_o = phase_q;

   // R9: the active octave only moves at a half-period boundary or during sleep
   a_r9_oct_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_q) |-> $past(term || sleep_i));

   // R2: the phase only flips when the terminal count was reached
   a_r2_phase_on_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(phase_q) && !$past(sleep_i)) |-> $past(term));

   // R6: sleep keeps the divider cleared
   a_r6_sleep_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_i |=> (cnt_q == '0) && !phase_q);

   // R7: leaving sleep starts from a zero count with the phase low
   a_r7_wake_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sleep_i) |-> (cnt_q == '0) && !phase_q);

endmodule

// File: rtl/octdiv_outgate.sv
module octdiv_outgate
   import octdiv_pkg::*;
(
   input  logic     phase_i,
   input  out_cfg_e cfg_i,
   input  logic     oe_i,
   output logic     main_o,
   output logic     aux_o
);

   logic main_en;
   logic aux_en;

   assign main_en = main_enabled(cfg_i);
   assign aux_en  = aux_enabled(cfg_i);

   // Output enable gates combinationally so it acts without a clock edge.
   assign main_o = oe_i & main_en &  phase_i;
   assign aux_o  = oe_i & aux_en  & ~phase_i;

endmodule

// File: rtl/octave_clock_divider.sv
module octave_clock_divider
   import octdiv_pkg::*;
#(
   parameter int unsigned OCT_W = 4,
   parameter int unsigned DAC_W = 10
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     upd_valid_i,
   input  logic [OCT_W+DAC_W+1:0]   upd_word_i,
   input  logic                     oe_i,
   output logic                     clk_main_o,
   output logic                     clk_aux_o,
   output logic [DAC_W-1:0]         dac_code_o
);

   logic [OCT_W-1:0] oct_nxt;
   out_cfg_e         cfg_q;
   logic             phase;
   logic             sleep;

   octdiv_regs #(.OCT_W(OCT_W), .DAC_W(DAC_W)) i_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_valid_i (upd_valid_i),
      .upd_word_i  (upd_word_i),
      .oct_nxt_o   (oct_nxt),
      .cfg_o       (cfg_q),
      .dac_o       (dac_code_o)
   );

   assign sleep = (cfg_q == CFG_SLEEP);

   octdiv_counter #(.OCT_W(OCT_W)) i_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sleep_i   (sleep),
      .oct_nxt_i (oct_nxt),
      .phase_o   (phase)
   );

   octdiv_outgate i_outgate (
      .phase_i (phase),
      .cfg_i   (cfg_q),
      .oe_i    (oe_i),
      .main_o  (clk_main_o),
      .aux_o   (clk_aux_o)
   );

   // R3: with both outputs on and enabled, they are complementary
   a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q == CFG_BOTH && oe_i) |-> (clk_main_o != clk_aux_o));

   // R4: main-only configuration keeps the auxiliary output low
   a_r4_aux_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q == CFG_MAIN_ONLY) |-> !clk_aux_o);

   // R5: aux-only configuration keeps the main output low
   a_r5_main_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q == CFG_AUX_ONLY) |-> !clk_main_o);

   // R6: sleep keeps both outputs low
   a_r6_sleep_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep |-> (!clk_main_o && !clk_aux_o));

endmodule

// File: tb/test_octave_clock_divider.sv
module test_octave_clock_divider;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [15:0] upd_word = '0;
   logic        oe = 1'b1;
   logic        clk_main;
   logic        clk_aux;
   logic [9:0]  dac_code;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   octave_clock_divider i_octave_clock_divider (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .upd_valid_i (upd_valid),
      .upd_word_i  (upd_word),
      .oe_i        (oe),
      .clk_main_o  (clk_main),
      .clk_aux_o   (clk_aux),
      .dac_code_o  (dac_code)
   );

   function automatic logic [15:0] mk(input int oct, input int dac, input int cfg);
      return {oct[3:0], dac[9:0], cfg[1:0]};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Called at a negedge; the strobe is sampled on the next posedge.
   task automatic write(input logic [15:0] w);
      upd_valid = 1'b1;
      upd_word  = w;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic count_until_main(input logic val, output int k);
      k = -1;
      for (int i = 1; i <= 70000; i++) begin
         @(negedge clk);
         if (clk_main == val) begin
            k = i;
            break;
         end
      end
   endtask

   task automatic restart(input int oct);
      write(mk(oct, 0, 3));
      repeat (2) @(negedge clk);
      write(mk(oct, 0, 0));
   endtask

   task automatic t_reset();
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 main low", clk_main, 0);
      check("R1 aux high", clk_aux, 1);
      check("R1 trim zero", dac_code, 0);
      count_until_main(1'b1, k);
      check("R1 first rise", k, 32768);
   endtask

   task automatic t_octaves();
      int k;
      int octs[4] = '{15, 14, 12, 9};
      foreach (octs[j]) begin
         restart(octs[j]);
         count_until_main(1'b1, k);
         check("R2 R7 first half", k, 1 << (15 - octs[j]));
         count_until_main(1'b0, k);
         check("R2 second half", k, 1 << (15 - octs[j]));
      end
   endtask

   task automatic t_modes();
      int tog;
      int bad;
      logic prev;
      restart(13);
      bad = 0; tog = 0; prev = clk_main;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (clk_aux == clk_main) bad++;
         if (clk_main != prev) tog++;
         prev = clk_main;
      end
      check("R3 aux inverse", bad, 0);
      check("R3 main toggles", tog, 4);
      write(mk(13, 0, 1));
      bad = 0; tog = 0; prev = clk_main;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (clk_aux) bad++;
         if (clk_main != prev) tog++;
         prev = clk_main;
      end
      check("R4 aux held low", bad, 0);
      check("R4 main toggles", tog, 4);
      write(mk(13, 0, 2));
      bad = 0; tog = 0; prev = clk_aux;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (clk_main) bad++;
         if (clk_aux != prev) tog++;
         prev = clk_aux;
      end
      check("R5 main held low", bad, 0);
      check("R5 aux toggles", tog, 4);
   endtask

   task automatic t_sleep();
      int bad;
      int k;
      write(mk(12, 0, 3));
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (clk_main || clk_aux) bad++;
      end
      check("R6 both low in sleep", bad, 0);
      write(mk(12, 0, 0));
      check("R7 main low on wake", clk_main, 0);
      check("R7 aux high on wake", clk_aux, 1);
      count_until_main(1'b1, k);
      check("R7 first rise after wake", k, 8);
   endtask

   task automatic t_oe();
      int bad;
      restart(13);
      repeat (2) @(negedge clk);
      check("R8 one output high before", clk_main | clk_aux, 1);
      #2 oe = 1'b0;
      #1;
      check("R8 main low at once", clk_main, 0);
      check("R8 aux low at once", clk_aux, 0);
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (clk_main || clk_aux) bad++;
      end
      check("R8 held low", bad, 0);
      #2 oe = 1'b1;
      #1;
      check("R8 restored", clk_main ^ clk_aux, 1);
      @(negedge clk);
   endtask

   task automatic t_boundary();
      int k;
      // Update one cycle after a boundary: old half-period finishes first.
      restart(13);
      repeat (4) @(negedge clk);
      check("R9 main high at boundary", clk_main, 1);
      write(mk(11, 0, 0));
      count_until_main(1'b0, k);
      check("R9 old half kept", k, 3);
      count_until_main(1'b1, k);
      check("R9 new half applied", k, 16);
      // Update on the boundary edge itself: applied there.
      restart(13);
      repeat (3) @(negedge clk);
      write(mk(11, 0, 0));
      check("R9 toggled on coincident edge", clk_main, 1);
      count_until_main(1'b0, k);
      check("R9 coincident update length", k, 16);
   endtask

   task automatic t_fields();
      write(mk(13, 677, 1));
      check("R10 trim field", dac_code, 677);
      write(mk(13, 5, 0));
      check("R10 trim field low", dac_code, 5);
   endtask

   initial begin
      t_reset();
      t_octaves();
      t_modes();
      t_sleep();
      t_oe();
      t_boundary();
      t_fields();
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule